// File: doc/BRIEF.md
# Accumulator Logic Instruction Executor

This block carries out the byte-wide logic operations of an 8-bit microcontroller core: AND into the accumulator from four kinds of source, AND into a directly addressed memory byte (with the accumulator or with a constant as the second operand), clearing the accumulator and complementing it. A sequencer presents an opcode and up to two following instruction bytes with a one-cycle `instr_valid` strobe. The block then runs the operation against a small internal-RAM port and pulses `done`. Along with `done` it reports the architectural length in bytes and the machine-cycle count of the instruction.

The RAM port has a combinational read: `ram_rdata` must reflect `ram_addr` within the same cycle. A write happens at the clock edge on which `ram_we` is high. Working registers are RAM bytes at `bank_sel*8 + n`. The bank bits are taken at the moment the instruction is accepted. The accumulator is held inside the block. An even/odd parity flag of the accumulator is provided as an output. Any opcode outside the supported set is flagged and has no effect.

Top module: `acc_logic_exec`

## Requirements
- R1: After a synchronous active-low reset, `acc`, `done`, `illegal`, `ram_we`, `instr_len` and `instr_cycles` are all 0.
- R2: Opcodes 0x58 to 0x5F AND the RAM byte at address `bank*8 + opcode[2:0]` into `acc`. They report length 1 and 1 cycle.
- R3: Opcode 0x55 ANDs the RAM byte at the address given in byte 1 into `acc`. It reports length 2 and 1 cycle.
- R4: Opcodes 0x56 and 0x57 first read a pointer from `bank*8 + opcode[0]`, then AND the RAM byte at that pointer into `acc`. They report length 1 and 1 cycle.
- R5: Opcode 0x54 ANDs byte 1 into `acc` and does not write RAM. It reports length 2 and 1 cycle.
- R6: Opcode 0x52 writes `mem[byte1] & acc` back to address byte 1 and leaves `acc` unchanged. It reports length 2 and 1 cycle.
- R7: Opcode 0x53 writes `mem[byte1] & byte2` to address byte 1 and leaves `acc` unchanged. It reports length 3 and 2 cycles.
- R8: Opcode 0xE4 sets `acc` to 0x00 and opcode 0xF4 sets it to `~acc` (0x5C becomes 0xA3). Both report length 1 and 1 cycle, and neither writes RAM.
- R9: `parity` is 1 exactly when `acc` holds an odd number of one bits.
- R10: Any other opcode pulses `done` and `illegal` together on the cycle after acceptance, with length and cycles reported as 0. `acc` and RAM are left unchanged.
- R11: For a legal opcode, `done` rises two cycles after the accepting edge, or three cycles for 0x56/0x57, and stays high for one cycle. `instr_valid` is ignored while an instruction is in progress.
- R12: `ram_we` is asserted only for opcodes 0x52 and 0x53, on their final execute cycle. No other instruction changes RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction present; accepted when idle |
| opcode | input | 8 | Opcode byte |
| op_byte1 | input | 8 | First operand byte (direct address or immediate) |
| op_byte2 | input | 8 | Second operand byte (immediate for 0x53) |
| bank_sel | input | 2 | Working-register bank |
| ram_addr | output | 8 | Internal RAM address |
| ram_rdata | input | 8 | RAM read data, combinational from `ram_addr` |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| acc | output | 8 | Accumulator |
| parity | output | 1 | Odd-ones parity of `acc` |
| done | output | 1 | One-cycle completion strobe |
| illegal | output | 1 | Unsupported opcode, valid with `done` |
| instr_len | output | 2 | Instruction length in bytes, valid from `done` |
| instr_cycles | output | 2 | Machine cycles, valid from `done` |

## Verification
The assertions assume that `ram_rdata` settles combinationally from `ram_addr` in the same cycle. They also assume that the environment waits for `done` before it counts on the next instruction being accepted. The bench meets both conditions: it models the RAM as an array read continuously through `ram_addr`. It drives each instruction on a falling edge and waits for `done` before issuing the next one. The one deliberate exception is a strobe held across a busy cycle, used to show that the held strobe is ignored.

// File: rtl/acc_logic_pkg.sv
// Shared types for the accumulator logic executor.
// Assumes one opcode class per instruction and a three-state sequencer.
package acc_logic_pkg;

    typedef enum logic [3:0] {
        OP_RN,
        OP_DIR,
        OP_IND,
        OP_IMM,
        OP_DIR_A,
        OP_DIR_IMM,
        OP_CLR,
        OP_CPL,
        OP_BAD
    } op_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PTR,
        ST_EXEC
    } seq_state_e;

endpackage

// File: rtl/acc_decoder.sv
// Opcode decoder: classifies an opcode, extracts the register index and
// gives the architectural length and cycle count. Purely combinational.
// Assumes an 8-bit opcode; unsupported codes map to OP_BAD with zero length.
module acc_decoder
    import acc_logic_pkg::*;
#(
    parameter int RIDX_W = 3
) (
    input  logic [7:0]        opcode,
    output op_kind_e          kind,
    output logic [RIDX_W-1:0] ridx,
    output logic [1:0]        len,
    output logic [1:0]        cyc
);

    // Classify the opcode and attach its length and cycle count.
    always_comb begin
        kind = OP_BAD;
        ridx = '0;
        len  = 2'd0;
        cyc  = 2'd0;
        casez (opcode)
            8'b0101_1???: begin kind = OP_RN;      ridx = RIDX_W'(opcode[2:0]); len = 2'd1; cyc = 2'd1; end
            8'b0101_011?: begin kind = OP_IND;     ridx = RIDX_W'(opcode[0]);   len = 2'd1; cyc = 2'd1; end
            8'h55:        begin kind = OP_DIR;     len = 2'd2; cyc = 2'd1; end
            8'h54:        begin kind = OP_IMM;     len = 2'd2; cyc = 2'd1; end
            8'h52:        begin kind = OP_DIR_A;   len = 2'd2; cyc = 2'd1; end
            8'h53:        begin kind = OP_DIR_IMM; len = 2'd3; cyc = 2'd2; end
            8'hE4:        begin kind = OP_CLR;     len = 2'd1; cyc = 2'd1; end
            8'hF4:        begin kind = OP_CPL;     len = 2'd1; cyc = 2'd1; end
            default:      begin kind = OP_BAD; end
        endcase
    end

endmodule

// File: rtl/acc_addr_gen.sv
// RAM address generator: selects the working-register, direct or pointer
// address for the current sequencer phase.
// Assumes ADDR_W >= BANK_W + RIDX_W and that registers sit at bank*8+n.
module acc_addr_gen
    import acc_logic_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8,
    parameter int BANK_W = 2,
    parameter int RIDX_W = 3
) (
    input  op_kind_e          kind,
    input  logic              ptr_phase,
    input  logic              exec_phase,
    input  logic [BANK_W-1:0] bank,
    input  logic [RIDX_W-1:0] ridx,
    input  logic [DATA_W-1:0] dir_byte,
    input  logic [DATA_W-1:0] ptr,
    output logic [ADDR_W-1:0] addr
);

    localparam int PAD_W = ADDR_W - BANK_W - RIDX_W;

    logic [ADDR_W-1:0] reg_addr;

    // Working-register address: bank in the upper bits, index below.
    always_comb reg_addr = {{PAD_W{1'b0}}, bank, ridx};

    // Choose the address source for the active phase.
    always_comb begin
        addr = '0;
        if (ptr_phase) begin
            addr = reg_addr;
        end else if (exec_phase) begin
            case (kind)
                OP_RN:                       addr = reg_addr;
                OP_DIR, OP_DIR_A, OP_DIR_IMM: addr = ADDR_W'(dir_byte);
                OP_IND:                      addr = ADDR_W'(ptr);
                default:                     addr = '0;
            endcase
        end
    end

endmodule

// File: rtl/acc_alu.sv
// Logic unit: computes the new accumulator value or the write-back byte
// for the decoded operation. Combinational.
// Assumes rdata is the operand read in the execute phase.
module acc_alu
    import acc_logic_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  op_kind_e          kind,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] byte1,
    input  logic [DATA_W-1:0] byte2,
    output logic [DATA_W-1:0] acc_next,
    output logic              acc_load,
    output logic [DATA_W-1:0] wdata,
    output logic              wr
);

    // Produce either an accumulator update or a memory write-back.
    always_comb begin
        acc_next = acc;
        acc_load = 1'b0;
        wdata    = '0;
        wr       = 1'b0;
        case (kind)
            OP_RN, OP_DIR, OP_IND: begin acc_load = 1'b1; acc_next = acc & rdata; end
            OP_IMM:                begin acc_load = 1'b1; acc_next = acc & byte1; end
            OP_DIR_A:              begin wr = 1'b1; wdata = rdata & acc; end
            OP_DIR_IMM:            begin wr = 1'b1; wdata = rdata & byte2; end
            OP_CLR:                begin acc_load = 1'b1; acc_next = '0; end
            OP_CPL:                begin acc_load = 1'b1; acc_next = ~acc; end
            default:               ;
        endcase
    end

endmodule

// File: rtl/acc_logic_exec.sv
// Accumulator logic instruction executor (top).
// Accepts an instruction when idle, optionally fetches an indirect pointer,
// executes one RAM read (and write-back) and pulses done with length/cycles.
// Assumes combinational RAM read and a synchronous active-low reset.
module acc_logic_exec
    import acc_logic_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8,
    parameter int BANK_W = 2,
    parameter int RIDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [7:0]        opcode,
    input  logic [DATA_W-1:0] op_byte1,
    input  logic [DATA_W-1:0] op_byte2,
    input  logic [BANK_W-1:0] bank_sel,
    output logic [ADDR_W-1:0] ram_addr,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              ram_we,
    output logic [DATA_W-1:0] ram_wdata,
    output logic [DATA_W-1:0] acc,
    output logic              parity,
    output logic              done,
    output logic              illegal,
    output logic [1:0]        instr_len,
    output logic [1:0]        instr_cycles
);

    seq_state_e        state;
    op_kind_e          dec_kind, lat_kind;
    logic [RIDX_W-1:0] dec_ridx, lat_ridx;
    logic [1:0]        dec_len, dec_cyc, lat_len, lat_cyc;
    logic [DATA_W-1:0] lat_b1, lat_b2, ptr;
    logic [BANK_W-1:0] lat_bank;
    logic [DATA_W-1:0] alu_acc, alu_wdata;
    logic              alu_load, alu_wr;

    acc_decoder #(.RIDX_W(RIDX_W)) u_dec (
        .opcode (opcode),
        .kind   (dec_kind),
        .ridx   (dec_ridx),
        .len    (dec_len),
        .cyc    (dec_cyc)
    );

    acc_addr_gen #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BANK_W(BANK_W), .RIDX_W(RIDX_W)) u_addr (
        .kind       (lat_kind),
        .ptr_phase  (state == ST_PTR),
        .exec_phase (state == ST_EXEC),
        .bank       (lat_bank),
        .ridx       (lat_ridx),
        .dir_byte   (lat_b1),
        .ptr        (ptr),
        .addr       (ram_addr)
    );

    acc_alu #(.DATA_W(DATA_W)) u_alu (
        .kind     (lat_kind),
        .acc      (acc),
        .rdata    (ram_rdata),
        .byte1    (lat_b1),
        .byte2    (lat_b2),
        .acc_next (alu_acc),
        .acc_load (alu_load),
        .wdata    (alu_wdata),
        .wr       (alu_wr)
    );

    // Memory write happens only on the execute phase of a write-back form.
    always_comb begin
        ram_we    = (state == ST_EXEC) && alu_wr;
        ram_wdata = alu_wdata;
    end

    // Odd-ones parity of the accumulator.
    always_comb parity = ^acc;

    // Sequencer: accept, optional pointer fetch, execute, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            acc          <= '0;
            done         <= 1'b0;
            illegal      <= 1'b0;
            instr_len    <= 2'd0;
            instr_cycles <= 2'd0;
            lat_kind     <= OP_BAD;
            lat_ridx     <= '0;
            lat_len      <= 2'd0;
            lat_cyc      <= 2'd0;
            lat_b1       <= '0;
            lat_b2       <= '0;
            lat_bank     <= '0;
            ptr          <= '0;
        end else begin
            done    <= 1'b0;
            illegal <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (instr_valid) begin
                        if (dec_kind == OP_BAD) begin
                            done         <= 1'b1;
                            illegal      <= 1'b1;
                            instr_len    <= 2'd0;
                            instr_cycles <= 2'd0;
                        end else begin
                            lat_kind <= dec_kind;
                            lat_ridx <= dec_ridx;
                            lat_len  <= dec_len;
                            lat_cyc  <= dec_cyc;
                            lat_b1   <= op_byte1;
                            lat_b2   <= op_byte2;
                            lat_bank <= bank_sel;
                            state    <= (dec_kind == OP_IND) ? ST_PTR : ST_EXEC;
                        end
                    end
                end
                ST_PTR: begin
                    ptr   <= ram_rdata;
                    state <= ST_EXEC;
                end
                ST_EXEC: begin
                    if (alu_load) acc <= alu_acc;
                    done         <= 1'b1;
                    instr_len    <= lat_len;
                    instr_cycles <= lat_cyc;
                    state        <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R4: pointer fetch is always followed by the execute phase.
    p_ptr_then_exec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PTR) |=> (state == ST_EXEC));

    // R6: write-back with the accumulator leaves the accumulator alone.
    p_dira_keeps_acc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && lat_kind == OP_DIR_A) |=> $stable(acc));

    // R8: complement form inverts the accumulator.
    p_cpl_inverts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && lat_kind == OP_CPL) |=> (acc == ~$past(acc)));

    // R8: clear form zeroes the accumulator.
    p_clr_zeroes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && lat_kind == OP_CLR) |=> (acc == '0));

    // R10: an illegal report comes with done, no write and no accumulator change.
    p_illegal_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (done && !ram_we && $stable(acc)));

    // R11: execute phase ends in done and a return to idle.
    p_exec_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC) |=> (done && state == ST_IDLE));

    // R12: a RAM write is always followed by completion.
    p_write_then_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> (done && !illegal));

endmodule

// File: tb/sim_acc_logic_exec.sv
// Bench for acc_logic_exec: directed corners plus seeded random instructions,
// checked against a bench-side model of accumulator and RAM.
module sim_acc_logic_exec;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       instr_valid = 1'b0;
    logic [7:0] opcode = 8'h00, op_byte1 = 8'h00, op_byte2 = 8'h00;
    logic [1:0] bank_sel = 2'd0;
    logic [7:0] ram_addr, ram_rdata, ram_wdata, acc;
    logic       ram_we, parity, done, illegal;
    logic [1:0] instr_len, instr_cycles;

    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    logic [7:0] exp_acc = 8'h00;
    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign ram_rdata = mem[ram_addr];
    always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;

    acc_logic_exec u0 (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .opcode(opcode),
        .op_byte1(op_byte1), .op_byte2(op_byte2), .bank_sel(bank_sel),
        .ram_addr(ram_addr), .ram_rdata(ram_rdata), .ram_we(ram_we),
        .ram_wdata(ram_wdata), .acc(acc), .parity(parity), .done(done),
        .illegal(illegal), .instr_len(instr_len), .instr_cycles(instr_cycles)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    // Bench classification: 0 rn,1 dir,2 ind,3 imm,4 dirA,5 dirImm,6 clr,7 cpl,8 bad
    function automatic int classify(input logic [7:0] op);
        if (op[7:3] == 5'b01011) return 0;
        if (op == 8'h55) return 1;
        if (op[7:1] == 7'b0101011) return 2;
        if (op == 8'h54) return 3;
        if (op == 8'h52) return 4;
        if (op == 8'h53) return 5;
        if (op == 8'hE4) return 6;
        if (op == 8'hF4) return 7;
        return 8;
    endfunction

    function automatic int exp_length(input int k);
        case (k)
            0, 2, 6, 7: return 1;
            1, 3, 4:    return 2;
            5:          return 3;
            default:    return 0;
        endcase
    endfunction

    task automatic run_instr(input logic [7:0] op, input logic [7:0] b1,
                             input logic [7:0] b2, input logic [1:0] bk, input int hold);
        int k, exp_lat, lat, exp_cyc;
        logic [7:0] a_reg, p;
        bit mem_ok;
        string tag;
        k = classify(op);
        exp_lat = (k == 8) ? 1 : ((k == 2) ? 3 : 2);
        exp_cyc = (k == 5) ? 2 : ((k == 8) ? 0 : 1);
        a_reg = {3'b000, bk, op[2:0]};
        case (k)
            0: begin exp_acc = exp_acc & exp_mem[a_reg]; tag = "R2"; end
            1: begin exp_acc = exp_acc & exp_mem[b1]; tag = "R3"; end
            2: begin p = exp_mem[{3'b000, bk, 2'b00, op[0]}]; exp_acc = exp_acc & exp_mem[p]; tag = "R4"; end
            3: begin exp_acc = exp_acc & b1; tag = "R5"; end
            4: begin exp_mem[b1] = exp_mem[b1] & exp_acc; tag = "R6"; end
            5: begin exp_mem[b1] = exp_mem[b1] & b2; tag = "R7"; end
            6: begin exp_acc = 8'h00; tag = "R8"; end
            7: begin exp_acc = ~exp_acc; tag = "R8"; end
            default: tag = "R10";
        endcase
        @(negedge clk);
        instr_valid = 1'b1; opcode = op; op_byte1 = b1; op_byte2 = b2; bank_sel = bk;
        lat = 0;
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            if (i == hold) instr_valid = 1'b0;
            if (done) begin lat = i; break; end
        end
        instr_valid = 1'b0;
        chk(lat == exp_lat, {tag, "/R11 latency"}, lat, exp_lat);
        chk(acc == exp_acc, {tag, " acc"}, acc, exp_acc);
        chk(illegal == (k == 8), {tag, "/R10 illegal flag"}, illegal, (k == 8));
        chk(instr_len == 2'(exp_length(k)), {tag, " length"}, instr_len, exp_length(k));
        chk(instr_cycles == 2'(exp_cyc), {tag, " cycles"}, instr_cycles, exp_cyc);
        chk(parity == ^exp_acc, "R9 parity", parity, ^exp_acc);
        mem_ok = 1'b1;
        for (int j = 0; j < 256; j++) if (mem[j] != exp_mem[j]) mem_ok = 1'b0;
        chk(mem_ok, {tag, "/R12 ram contents"}, mem_ok, 1);
        @(negedge clk);
        chk(done == 1'b0, "R11 done single pulse", done, 0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int j = 0; j < 256; j++) begin
            mem[j] = 8'($urandom);
            exp_mem[j] = mem[j];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(acc == 8'h00 && done == 1'b0 && illegal == 1'b0 && ram_we == 1'b0
            && instr_len == 2'd0 && instr_cycles == 2'd0, "R1 reset state", acc, 0);
        // R8: complement of 0, then build 0x5C and complement to 0xA3.
        run_instr(8'hF4, 8'h00, 8'h00, 2'd0, 1);
        run_instr(8'h54, 8'h5C, 8'h00, 2'd0, 1);
        run_instr(8'hF4, 8'h00, 8'h00, 2'd0, 1);
        chk(acc == 8'hA3, "R8 complement of 0x5C", acc, 8'hA3);
        // R10: unsupported codes, including neighbours of the AND group.
        run_instr(8'h50, 8'h11, 8'h22, 2'd1, 1);
        run_instr(8'h51, 8'h11, 8'h22, 2'd2, 1);
        run_instr(8'hFF, 8'h11, 8'h22, 2'd3, 1);
        // R2/R4: each bank, highest register and both pointer registers.
        run_instr(8'hE4, 8'h00, 8'h00, 2'd0, 1);
        run_instr(8'hF4, 8'h00, 8'h00, 2'd0, 1);
        run_instr(8'h5F, 8'h00, 8'h00, 2'd3, 1);
        run_instr(8'hF4, 8'h00, 8'h00, 2'd0, 1);
        run_instr(8'h57, 8'h00, 8'h00, 2'd2, 1);
        run_instr(8'h56, 8'h00, 8'h00, 2'd1, 1);
        // R6/R7: write-back with accumulator and with immediate at a register address.
        run_instr(8'hF4, 8'h00, 8'h00, 2'd0, 1);
        run_instr(8'h52, 8'h08, 8'h00, 2'd0, 1);
        run_instr(8'h53, 8'hFF, 8'h0F, 2'd0, 1);
        // R11: strobe held across the busy cycle is ignored (one complement only).
        run_instr(8'hF4, 8'h00, 8'h00, 2'd0, 2);
        // Random mix.
        for (int n = 0; n < 300; n++) begin
            logic [7:0] op;
            case ($urandom % 10)
                0: op = 8'h58 | 8'($urandom % 8);
                1: op = 8'h55;
                2: op = 8'h56 | 8'($urandom % 2);
                3: op = 8'h54;
                4: op = 8'h52;
                5: op = 8'h53;
                6: op = 8'hE4;
                7, 8: op = 8'hF4;
                default: op = 8'($urandom);
            endcase
            run_instr(op, 8'($urandom), 8'($urandom), 2'($urandom), 1);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R11: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule